// File: doc/BRIEF.md
# Axis Limit and Reference Monitor

This block watches the two end-of-travel switches and an optional reference switch of one motion axis. Each switch input is first passed through a synchroniser. A configuration bit assigns one physical switch to the inward end and the other to the outward end. From the commanded direction the block then raises `limit_hit` when the switch at the end the axis is heading towards closes. The flag stays latched even if that switch bounces open again, and it clears only when the direction is reversed.

A second state machine watches the reference signal. The reference is either a dedicated zero switch or, when no such switch is fitted, the inward limit itself. When the reference rises while the axis is running inward, the machine emits a single-cycle `pos_clear` pulse that the position counter uses to return to zero. A reference edge taken in any other condition is consumed without a pulse. No further pulse can occur until the reference has gone low again.

The limit latch has two states. `LIM_CLEAR` moves to `LIM_HELD` on the transition "limit ahead", and `LIM_HELD` returns to `LIM_CLEAR` on the transition "direction reversed". The reference machine has four states. `REF_IDLE` waits out the synchroniser fill after reset and then takes "reference low" to `REF_ARMED`. From `REF_ARMED`, "reference rises while running inward" leads to `REF_FIRE`, and "reference rises otherwise" leads to `REF_SPENT`. `REF_FIRE` always moves to `REF_SPENT` after one cycle. `REF_SPENT` returns to `REF_ARMED` on "reference low".

Top module: `axis_limit_monitor`

## Requirements
- R1: A change on any raw switch input affects the outputs exactly three clock edges later: two synchroniser stages plus the state register.
- R2: With `cfg_swap`=0, limit A is the inward limit and limit B the outward limit. With `cfg_swap`=1 the two roles are exchanged.
- R3: `limit_hit` is set only by the limit in the direction of travel (`move_out`=0 inward, 1 outward). The limit on the opposite end has no effect on it.
- R4: Once set, `limit_hit` stays high while `move_out` is unchanged, even after the switch opens.
- R5: A change of `move_out` clears `limit_hit` on the next clock edge.
- R6: With `cfg_zero_present`=1 the reference is the zero switch. With 0 it is the inward limit.
- R7: A rising reference while `running`=1 and `move_out`=0 produces a `pos_clear` pulse exactly one cycle long. A rising reference while moving outward or while stopped produces no pulse.
- R8: After a reference edge, whether or not it pulsed, no further pulse occurs until the reference has been low. Starting a run with the reference already high gives no pulse.
- R9: In reset both outputs are 0. A reference that is already high when reset is released produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_a_raw | input | 1 | Raw limit switch A, active high |
| lim_b_raw | input | 1 | Raw limit switch B, active high |
| zero_raw | input | 1 | Raw zero-reference switch, active high |
| move_out | input | 1 | Direction of travel: 0 inward, 1 outward |
| running | input | 1 | High while a move is in progress |
| cfg_swap | input | 1 | Exchanges the inward and outward roles of limits A and B |
| cfg_zero_present | input | 1 | A physical zero switch is fitted and used as the reference |
| limit_hit | output | 1 | Latched limit in the current direction of travel |
| pos_clear | output | 1 | One-cycle position reset at the reference point |

## Verification
The limit latch is driven with each limit closing in the matching direction and in the opposite direction, under both swap settings. This separates a correct switch-to-end mapping from a swapped one, and direction-aware blocking from plain OR-ing of the switches. The switch is then released under a constant direction and the direction is reversed. This distinguishes a true latch from a follower, and the single-edge timing of the clear is checked separately from the three-edge input latency. The reference machine sees rising edges while inward and running, while outward, while stopped, and with the reference held high across reset. It sees them with the zero switch and with the inward limit as the source, and pulses are counted over a window, which exposes missing edge detection, a missing re-arm rule and a wrong source selection.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam logic DIR_INWARD = 1'b0;

    typedef enum logic {
        LIM_CLEAR,
        LIM_HELD
    } lim_state_t;

    typedef enum logic [1:0] {
        REF_IDLE,
        REF_ARMED,
        REF_FIRE,
        REF_SPENT
    } ref_state_t;
endpackage

// File: rtl/alm_sync.sv
module alm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/alm_limit_latch.sv
module alm_limit_latch
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_lim,
    input  logic out_lim,
    input  logic move_out,
    output logic blocked
);
    lim_state_t state_q, state_d;
    logic       dir_q;
    logic       dir_flip;
    logic       ahead;

    assign dir_flip = (move_out != dir_q);
    assign ahead    = (move_out == DIR_INWARD) ? in_lim : out_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LIM_CLEAR;
            dir_q   <= DIR_INWARD;
        end else begin
            state_q <= state_d;
            dir_q   <= move_out;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LIM_CLEAR: if (!dir_flip && ahead) state_d = LIM_HELD;
            LIM_HELD:  if (dir_flip)           state_d = LIM_CLEAR;
            default:                           state_d = LIM_CLEAR;
        endcase
    end

    always_comb begin
        blocked = (state_q == LIM_HELD);
    end
endmodule

// File: rtl/alm_ref_fsm.sv
module alm_ref_fsm
    import alm_pkg::*;
#(
    parameter int FILL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    input  logic moving_in,
    output logic pulse
);
    localparam int CW = $clog2(FILL_CYCLES + 1);
    localparam logic [CW-1:0] FILL_DONE = CW'(FILL_CYCLES);

    ref_state_t    state_q, state_d;
    logic [CW-1:0] fill_q;
    logic          filled;

    assign filled = (fill_q == FILL_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REF_IDLE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!filled) fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_IDLE:  if (filled && !ref_lvl) state_d = REF_ARMED;
            REF_ARMED: if (ref_lvl)            state_d = moving_in ? REF_FIRE : REF_SPENT;
            REF_FIRE:                          state_d = REF_SPENT;
            REF_SPENT: if (!ref_lvl)           state_d = REF_ARMED;
            default:                           state_d = REF_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == REF_FIRE);
    end
endmodule

// File: rtl/axis_limit_monitor.sv
module axis_limit_monitor
    import alm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lim_a_raw,
    input  logic lim_b_raw,
    input  logic zero_raw,
    input  logic move_out,
    input  logic running,
    input  logic cfg_swap,
    input  logic cfg_zero_present,
    output logic limit_hit,
    output logic pos_clear
);
    localparam int NSW = 3;

    logic [NSW-1:0] raw_sw, sync_sw;
    logic           in_lim_s, out_lim_s, ref_lvl;

    assign raw_sw = {zero_raw, lim_b_raw, lim_a_raw};

    alm_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_sw),
        .q     (sync_sw)
    );

    assign in_lim_s  = cfg_swap ? sync_sw[1] : sync_sw[0];
    assign out_lim_s = cfg_swap ? sync_sw[0] : sync_sw[1];
    assign ref_lvl   = cfg_zero_present ? sync_sw[2] : in_lim_s;

    alm_limit_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_lim   (in_lim_s),
        .out_lim  (out_lim_s),
        .move_out (move_out),
        .blocked  (limit_hit)
    );

    alm_ref_fsm #(.FILL_CYCLES(SYNC_STAGES)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_lvl   (ref_lvl),
        .moving_in (running && (move_out == DIR_INWARD)),
        .pulse     (pos_clear)
    );
endmodule

// File: rtl/alm_checks.sv
module alm_checks (
    input logic clk,
    input logic rst_n,
    input logic move_out,
    input logic running,
    input logic limit_hit,
    input logic pos_clear,
    input logic in_lim_s,
    input logic out_lim_s,
    input logic ref_lvl
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_clear |=> !pos_clear); // R7
    AST_CLEAR_MOVING_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pos_clear) |-> $past(running && !move_out)); // R7
    AST_CLEAR_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pos_clear) |-> $past(ref_lvl)); // R6
    AST_REVERSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (move_out != $past(move_out))) |=> !limit_hit); // R5
    AST_HOLD_UNTIL_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && limit_hit && $stable(move_out)) |=> limit_hit); // R4
    AST_SET_NEEDS_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(limit_hit)) |-> $past(move_out ? out_lim_s : in_lim_s)); // R3
endmodule

bind axis_limit_monitor alm_checks u_alm_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .move_out  (move_out),
    .running   (running),
    .limit_hit (limit_hit),
    .pos_clear (pos_clear),
    .in_lim_s  (in_lim_s),
    .out_lim_s (out_lim_s),
    .ref_lvl   (ref_lvl)
);

// File: tb/tb_axis_limit_monitor.sv
module tb_axis_limit_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // {swap, zero_present, move_out, running, a, b, z, exp_hit, exp_clear}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b000000000, // idle
        9'b000001000, // R3 outward limit ignored while inward
        9'b001001010, // R2 R3 B is outward limit
        9'b001000010, // R4 release keeps latch
        9'b000000000, // R5 reversal clears
        9'b100001010, // R2 swapped: B inward; R8 edge while stopped
        9'b100101010, // R8 run with reference already high
        9'b100100010, // R4 latched; reference low re-arms
        9'b100101011, // R7 edge running inward fires
        9'b100101010, // R8 no second pulse
        9'b100100010, // reference low
        9'b011100000, // R6 zero switch source; outward
        9'b011100100, // R7 edge while outward: no pulse
        9'b010100000, // inward, reference low
        9'b010110010, // R6 in-limit is not the reference now
        9'b010110111, // R6 R7 zero switch edge fires
        9'b011010000  // R3 inward limit ignored while outward
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lim_a_raw = 1'b0, lim_b_raw = 1'b0, zero_raw = 1'b0;
    logic move_out = 1'b0, running = 1'b0;
    logic cfg_swap = 1'b0, cfg_zero_present = 1'b0;
    logic limit_hit, pos_clear;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axis_limit_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .lim_a_raw(lim_a_raw), .lim_b_raw(lim_b_raw), .zero_raw(zero_raw),
        .move_out(move_out), .running(running),
        .cfg_swap(cfg_swap), .cfg_zero_present(cfg_zero_present),
        .limit_hit(limit_hit), .pos_clear(pos_clear)
    );

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic count_pulses(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (pos_clear === 1'b1) n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(limit_hit, 1'b0, "R9 hit in reset");
        check(pos_clear, 1'b0, "R9 clear in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            {cfg_swap, cfg_zero_present, move_out, running,
             lim_a_raw, lim_b_raw, zero_raw} = VEC[v][8:2];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(limit_hit, VEC[v][1], $sformatf("R3 vector %0d hit", v));
            check(pos_clear, VEC[v][0], $sformatf("R7 vector %0d clear", v));
        end

        // R1: latency of three edges (outward, B closes)
        lim_b_raw = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(limit_hit, 1'b0, "R1 not yet after two edges");
        @(posedge clk);
        @(negedge clk);
        check(limit_hit, 1'b1, "R1 set after three edges");

        // R5: reversal clears on the very next edge
        move_out = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(limit_hit, 1'b0, "R5 cleared one edge after reversal");
        lim_a_raw = 1'b0;
        lim_b_raw = 1'b0;
        repeat (6) @(negedge clk);

        // R9: reference high across reset release gives no pulse
        cfg_zero_present = 1'b1;
        zero_raw = 1'b1;
        running = 1'b1;
        move_out = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(limit_hit, 1'b0, "R9 hit during reset");
        check(pos_clear, 1'b0, "R9 clear during reset");
        rst_n = 1'b1;
        count_pulses(10, n);
        check(n == 0, 1'b1, "R9 no pulse with reference high at release");

        // R8: low then high gives exactly one pulse over a long window
        zero_raw = 1'b0;
        repeat (5) @(negedge clk);
        zero_raw = 1'b1;
        count_pulses(12, n);
        check(n == 1, 1'b1, "R8 exactly one pulse per reference edge");

        // R6: with zero switch present the in-limit edge does not fire
        zero_raw = 1'b0;
        repeat (5) @(negedge clk);
        lim_a_raw = 1'b1;
        count_pulses(8, n);
        check(n == 0, 1'b1, "R6 in-limit ignored as reference");
        lim_a_raw = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule